// File: doc/BRIEF.md
# BCD clock-calendar counter

This block keeps wall-clock time as seven packed-BCD bytes: seconds, minutes, hours, day of month, month, two-digit year and day of week. A prescaler counts pulses of a 32.768 kHz timebase enable, and the counter steps forward once each time a full second of those pulses has gone by. Seconds carry into minutes and minutes into hours. Hours carry into the date, the date into the month and the month into the year. The length of each month is corrected, and years divisible by four are treated as leap years.

A host loads any field through a byte-wide write port. Time writes are refused unless an unlock input is high. Every accepted write restarts the second phase. The time stays frozen after a cold start until the host writes it once, and a clock-fail output shows this condition. An external event detector can also freeze the time, but only when a halt option has been armed beforehand. A later accepted write releases the freeze and disarms the option. For reads, a capture strobe copies all seven fields into a shadow set, so a multi-byte read cannot mix values from before and after a carry.

The hour byte selects its own format. In 24-hour form, bit 7 is set. In 12-hour form, bit 7 is clear and bit 5 flags PM.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the fields read back as seconds 00, minutes 00, hour 8'h12 (12-hour mode, 12 AM), date 01, month 01, year 00, day of week 00. `clk_fail` is 1, and `halted` and `halt_armed` are 0.
- R2: Field addresses are 0 seconds, 1 minutes, 2 hour, 3 date, 4 month, 5 year, 6 day of week. A write loads `wr_data` only when `wr_unlock` is 1 and the address is at most 6. Any other write changes nothing and is not counted as a time write.
- R3: While `clk_fail` is 1 the fields never advance. The first accepted write clears `clk_fail` and lets counting begin.
- R4: An accepted write restarts the prescaler. The first increment afterwards happens on exactly the TICKS_PER_SEC-th `tick_in` pulse following that write.
- R5: Seconds and minutes count in BCD from 00 to 59. At 59 each one wraps to 00 and carries into the next field.
- R6: 24-hour mode (hour bit 7 = 1, hour in bits 5:0) counts 00 to 23. The step from 23 to 00 carries into the date.
- R7: 12-hour mode (hour bit 7 = 0, bit 5 = PM, hour in bits 4:0) runs 12, 01 … 11. The PM flag toggles on each 11→12 step. Only the step from 11 PM to 12 AM carries into the date.
- R8: The date wraps to 01 and carries into the month after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February.
- R9: February ends on day 29 when the BCD year is divisible by 4 (including 00) and on day 28 otherwise.
- R10: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R11: Day of week steps 0 … 6 and then back to 0, once per date carry.
- R12: Pulsing `halt_arm` sets `halt_armed`. An `event_in` pulse while armed sets `halted`, and then the fields stop advancing. An `event_in` pulse while not armed has no effect. An accepted write clears both flags and counting resumes.
- R13: `rd_start` copies all seven fields into a shadow set. `rd_data` shows the shadow byte chosen by `rd_addr` (0 for addresses above 6), and later increments do not change it until the next `rd_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; models a total power loss |
| tick_in | input | 1 | One-cycle enable per 32.768 kHz timebase period |
| wr_en | input | 1 | Field write strobe |
| wr_unlock | input | 1 | Time write permission bit |
| wr_addr | input | 3 | Field address for writes |
| wr_data | input | 8 | BCD byte to load |
| rd_start | input | 1 | Capture all fields into the shadow set |
| rd_addr | input | 3 | Shadow field selected onto rd_data |
| rd_data | output | 8 | Selected shadow byte |
| halt_arm | input | 1 | Arms the halt-on-event option |
| event_in | input | 1 | Event detector output |
| clk_fail | output | 1 | Time not yet set since power loss |
| halted | output | 1 | Counting frozen by an event |
| halt_armed | output | 1 | Halt-on-event option is armed |

## Verification
A corrupted carry or month-length decision is not visible until the affected boundary is reached. After that it shows in the next capture of every field further up the chain, so each rollover test reads all the fields that the carry should touch. A prescaler phase error appears one tick early or late at the first increment after a write, which the bench checks to the exact tick. A stale freeze flag shows at once as seconds failing to move, and stale shadow storage shows as the wrong byte on `rd_data` without any further capture.

// File: rtl/rtc_pkg.sv
// Shared types and BCD helpers for the clock-calendar counter.
// Assumes all fields hold valid packed BCD as loaded by the host.
package rtc_pkg;
    localparam int FIELD_W = 8;
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] A_SEC   = 3'd0;
    localparam logic [ADDR_W-1:0] A_MIN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_HOUR  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DATE  = 3'd3;
    localparam logic [ADDR_W-1:0] A_MONTH = 3'd4;
    localparam logic [ADDR_W-1:0] A_YEAR  = 3'd5;
    localparam logic [ADDR_W-1:0] A_DOW   = 3'd6;

    typedef struct packed {
        logic [FIELD_W-1:0] sec;
        logic [FIELD_W-1:0] min;
        logic [FIELD_W-1:0] hour;
        logic [FIELD_W-1:0] date;
        logic [FIELD_W-1:0] month;
        logic [FIELD_W-1:0] year;
        logic [FIELD_W-1:0] dow;
    } rtc_time_t;

    localparam rtc_time_t RESET_TIME = '{sec: 8'h00, min: 8'h00, hour: 8'h12,
                                         date: 8'h01, month: 8'h01, year: 8'h00,
                                         dow: 8'h00};

    // Add one to a packed-BCD byte, carrying the units digit into the tens nibble.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // A BCD year 10t+o is divisible by 4 exactly when 2t+o is.
    function automatic logic is_leap(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    // Last valid date of a month, in BCD.
    function automatic logic [7:0] last_date(input logic [7:0] mo, input logic leap);
        case (mo)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // One hour step in either format; bit 8 of the result is the day carry.
    function automatic logic [8:0] hour_step(input logic [7:0] h);
        logic [7:0] n;
        logic       carry;
        carry = 1'b0;
        if (h[7]) begin
            if (h[5:0] == 6'h23) begin
                n     = 8'h80;
                carry = 1'b1;
            end else begin
                n = bcd_inc(h);
            end
        end else if (h[4:0] == 5'h11) begin
            n     = {2'b00, ~h[5], 5'h12};
            carry = h[5];
        end else if (h[4:0] == 5'h12) begin
            n = {h[7:5], 5'h01};
        end else begin
            n = bcd_inc(h);
        end
        return {carry, n};
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
// Divides the timebase enable down to a one-cycle second strobe.
// Assumes TICKS_PER_SEC >= 2. resync forces the phase back to zero.
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic resync,
    output logic sec_en
);
    localparam int CNT_W = $clog2(TICKS_PER_SEC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Strobe on the tick that completes a second, unless a restart is pending.
    assign sec_en = tick_in && (cnt_q == LAST) && !resync;

    // Count timebase ticks; clear on wrap or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (resync)           cnt_q <= '0;
        else if (tick_in) begin
            if (cnt_q == LAST)     cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_counter.sv
// Holds the seven BCD fields and applies either a host load or a one-second step.
// Assumes a load and a step never coincide (the top suppresses the step).
module rtc_counter
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [7:0]        load_data,
    output rtc_time_t         time_q
);
    rtc_time_t t_next;
    logic [8:0] hs;
    logic [7:0] last_d;

    // Next-second value with the full carry chain.
    always_comb begin
        t_next     = time_q;
        hs         = hour_step(time_q.hour);
        last_d     = last_date(time_q.month, is_leap(time_q.year));
        t_next.sec = bcd_inc(time_q.sec);
        if (time_q.sec == 8'h59) begin
            t_next.sec = 8'h00;
            t_next.min = bcd_inc(time_q.min);
            if (time_q.min == 8'h59) begin
                t_next.min  = 8'h00;
                t_next.hour = hs[7:0];
                if (hs[8]) begin
                    t_next.dow = (time_q.dow == 8'h06) ? 8'h00 : time_q.dow + 8'h01;
                    if (time_q.date == last_d) begin
                        t_next.date = 8'h01;
                        if (time_q.month == 8'h12) begin
                            t_next.month = 8'h01;
                            t_next.year  = (time_q.year == 8'h99) ? 8'h00 : bcd_inc(time_q.year);
                        end else begin
                            t_next.month = bcd_inc(time_q.month);
                        end
                    end else begin
                        t_next.date = bcd_inc(time_q.date);
                    end
                end
            end
        end
    end

    // Field storage: reset value, host load, or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= RESET_TIME;
        end else if (load) begin
            case (load_addr)
                A_SEC:   time_q.sec   <= load_data;
                A_MIN:   time_q.min   <= load_data;
                A_HOUR:  time_q.hour  <= load_data;
                A_DATE:  time_q.date  <= load_data;
                A_MONTH: time_q.month <= load_data;
                A_YEAR:  time_q.year  <= load_data;
                A_DOW:   time_q.dow   <= load_data;
                default: ;
            endcase
        end else if (advance) begin
            time_q <= t_next;
        end
    end
endmodule

// File: rtl/rtc_shadow.sv
// Captures all fields on request and serves one byte of the capture.
// Assumes the capture strobe is a single-cycle pulse from the host.
module rtc_shadow
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  rtc_time_t         time_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output rtc_time_t         shadow_q,
    output logic [7:0]        rd_data
);
    // Snapshot register.
    always_ff @(posedge clk) begin
        if (!rst_n)       shadow_q <= RESET_TIME;
        else if (capture) shadow_q <= time_in;
    end

    // Byte select from the snapshot.
    always_comb begin
        case (rd_addr)
            A_SEC:   rd_data = shadow_q.sec;
            A_MIN:   rd_data = shadow_q.min;
            A_HOUR:  rd_data = shadow_q.hour;
            A_DATE:  rd_data = shadow_q.date;
            A_MONTH: rd_data = shadow_q.month;
            A_YEAR:  rd_data = shadow_q.year;
            A_DOW:   rd_data = shadow_q.dow;
            default: rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/bcd_rtc_core.sv
// Top of the BCD clock-calendar: write gating, cold-start and event freeze,
// prescaler, field counter and read snapshot. Assumes single-cycle strobes.
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_in,
    input  logic        wr_en,
    input  logic        wr_unlock,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        rd_start,
    input  logic [2:0]  rd_addr,
    output logic [7:0]  rd_data,
    input  logic        halt_arm,
    input  logic        event_in,
    output logic        clk_fail,
    output logic        halted,
    output logic        halt_armed
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = A_DOW;

    logic      wr_acc;
    logic      sec_en;
    logic      advance;
    rtc_time_t time_q;
    rtc_time_t shadow_q;

    // A time write counts only when unlocked and aimed at a real field.
    assign wr_acc  = wr_en && wr_unlock && (wr_addr <= LAST_ADDR);
    // Step only when running and no load competes this cycle.
    assign advance = sec_en && !clk_fail && !halted && !wr_acc;

    // Cold-start flag: set by reset, cleared by the first time write.
    always_ff @(posedge clk) begin
        if (!rst_n)      clk_fail <= 1'b1;
        else if (wr_acc) clk_fail <= 1'b0;
    end

    // Halt option: armed by the host, disarmed by a time write.
    always_ff @(posedge clk) begin
        if (!rst_n)        halt_armed <= 1'b0;
        else if (wr_acc)   halt_armed <= 1'b0;
        else if (halt_arm) halt_armed <= 1'b1;
    end

    // Event freeze: set by an event while armed, released by a time write.
    always_ff @(posedge clk) begin
        if (!rst_n)                       halted <= 1'b0;
        else if (wr_acc)                  halted <= 1'b0;
        else if (halt_armed && event_in)  halted <= 1'b1;
    end

    rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .resync(wr_acc), .sec_en(sec_en)
    );

    rtc_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .advance(advance), .load(wr_acc),
        .load_addr(wr_addr), .load_data(wr_data), .time_q(time_q)
    );

    rtc_shadow u_shadow (
        .clk(clk), .rst_n(rst_n), .capture(rd_start), .time_in(time_q),
        .rd_addr(rd_addr), .shadow_q(shadow_q), .rd_data(rd_data)
    );
endmodule

// File: rtl/bcd_rtc_checker.sv
// Temporal checks on the clock-calendar control state; attached by bind.
module bcd_rtc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_acc,
    input logic        rd_start,
    input logic        clk_fail,
    input logic        halted,
    input logic        halt_armed,
    input logic [55:0] time_flat,
    input logic [55:0] shadow_flat
);
    p_frozen_cold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_fail && !wr_acc |=> $stable(time_flat));

    p_write_clears_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> !clk_fail);

    p_frozen_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
        halted && !wr_acc |=> $stable(time_flat));

    p_write_releases_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> !halted && !halt_armed);

    p_shadow_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_start |=> $stable(shadow_flat));
endmodule

bind bcd_rtc_core bcd_rtc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .rd_start(rd_start),
    .clk_fail(clk_fail), .halted(halted), .halt_armed(halt_armed),
    .time_flat(time_q), .shadow_flat(shadow_q)
);

// File: tb/bcd_rtc_core_tb_top.sv
module bcd_rtc_core_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0, tick_in = 1'b0, wr_en = 1'b0, wr_unlock = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic       rd_start = 1'b0, halt_arm = 1'b0, event_in = 1'b0;
    logic       clk_fail, halted, halt_armed;

    int checks = 0;
    int errors = 0;

    typedef struct { logic [2:0] a; logic [7:0] e; string tag; } item_t;
    item_t exp_q[$];

    bcd_rtc_core #(.TICKS_PER_SEC(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en), .wr_unlock(wr_unlock),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_start(rd_start), .rd_addr(rd_addr),
        .rd_data(rd_data), .halt_arm(halt_arm), .event_in(event_in),
        .clk_fail(clk_fail), .halted(halted), .halt_armed(halt_armed)
    );

    // Monitor: pop expected bytes and compare with rd_data mid-cycle.
    always @(negedge clk) begin
        item_t it;
        if (exp_q.size() > 0) begin
            it = exp_q.pop_front();
            checks++;
            if (rd_data !== it.e) begin
                errors++;
                $display("FAIL %s field %0d: actual %h expected %h", it.tag, it.a, rd_data, it.e);
            end
        end
    end

    // Driver: optionally capture, then queue the expected byte for field a.
    task automatic probe(input logic [2:0] a, input bit cap, input logic [7:0] e, input string tag);
        @(negedge clk); rd_addr = a; rd_start = cap;
        @(posedge clk); #1; rd_start = 1'b0;
        exp_q.push_back('{a, e, tag});
        @(negedge clk); #1;
    endtask

    task automatic see(input logic [2:0] a, input logic [7:0] e, input string tag);
        probe(a, 1'b1, e, tag);
    endtask

    task automatic chk(input logic act, input logic e, input string tag);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s flag: actual %b expected %b", tag, act, e);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1; wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_in = 1'b1;
            @(posedge clk); #1; tick_in = 1'b0;
        end
    endtask

    task automatic pulse_arm();
        @(negedge clk); halt_arm = 1'b1; @(posedge clk); #1; halt_arm = 1'b0;
    endtask

    task automatic pulse_event();
        @(negedge clk); event_in = 1'b1; @(posedge clk); #1; event_in = 1'b0;
    endtask

    // Load hh:59:59 and run one second.
    task automatic roll(input logic [7:0] h);
        wr(3'd0, 8'h59); wr(3'd1, 8'h59); wr(3'd2, h); ticks(4);
    endtask

    // Load date, month, year and cross midnight in 24-hour mode.
    task automatic day_end(input logic [7:0] d, input logic [7:0] m, input logic [7:0] y);
        wr(3'd3, d); wr(3'd4, m); wr(3'd5, y); roll(8'hA3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        see(3'd0, 8'h00, "R1"); see(3'd1, 8'h00, "R1"); see(3'd2, 8'h12, "R1");
        see(3'd3, 8'h01, "R1"); see(3'd4, 8'h01, "R1"); see(3'd5, 8'h00, "R1");
        see(3'd6, 8'h00, "R1");
        chk(clk_fail, 1'b1, "R1"); chk(halted, 1'b0, "R1"); chk(halt_armed, 1'b0, "R1");
        // R3 no counting before first write
        ticks(8); see(3'd0, 8'h00, "R3");
        // R2 locked write and out-of-range address ignored
        wr(3'd0, 8'h30); see(3'd0, 8'h00, "R2"); chk(clk_fail, 1'b1, "R2");
        wr_unlock = 1'b1;
        wr(3'd7, 8'h30); chk(clk_fail, 1'b1, "R2"); see(3'd0, 8'h00, "R2");
        // R3 first write, R4 phase restart
        wr(3'd0, 8'h30); chk(clk_fail, 1'b0, "R3");
        ticks(3); see(3'd0, 8'h30, "R4");
        ticks(1); see(3'd0, 8'h31, "R4");
        ticks(2); wr(3'd1, 8'h10); ticks(3); see(3'd0, 8'h31, "R4");
        ticks(1); see(3'd0, 8'h32, "R4"); see(3'd1, 8'h10, "R2");
        // R2 locked write while running
        wr_unlock = 1'b0; wr(3'd1, 8'h44); see(3'd1, 8'h10, "R2"); wr_unlock = 1'b1;
        // R5 seconds and minutes carry, R6 hour step
        wr(3'd0, 8'h58); wr(3'd1, 8'h59); wr(3'd2, 8'hA2); ticks(8);
        see(3'd0, 8'h00, "R5"); see(3'd1, 8'h00, "R5"); see(3'd2, 8'hA3, "R6");
        // R6 midnight, R11 day-of-week wrap
        wr(3'd6, 8'h06); day_end(8'h15, 8'h06, 8'h24);
        see(3'd2, 8'h80, "R6"); see(3'd3, 8'h16, "R6"); see(3'd6, 8'h00, "R11");
        roll(8'hA3); see(3'd6, 8'h01, "R11");
        // R7 12-hour sequence
        wr(3'd3, 8'h10);
        roll(8'h11); see(3'd2, 8'h32, "R7"); see(3'd3, 8'h10, "R7");
        roll(8'h32); see(3'd2, 8'h21, "R7");
        roll(8'h31); see(3'd2, 8'h12, "R7"); see(3'd3, 8'h11, "R7");
        roll(8'h12); see(3'd2, 8'h01, "R7");
        // R8 month lengths
        day_end(8'h30, 8'h04, 8'h24); see(3'd3, 8'h01, "R8"); see(3'd4, 8'h05, "R8");
        day_end(8'h30, 8'h01, 8'h24); see(3'd3, 8'h31, "R8"); see(3'd4, 8'h01, "R8");
        // R9 February
        day_end(8'h28, 8'h02, 8'h24); see(3'd3, 8'h29, "R9");
        roll(8'hA3); see(3'd3, 8'h01, "R9"); see(3'd4, 8'h03, "R9");
        day_end(8'h28, 8'h02, 8'h23); see(3'd3, 8'h01, "R9"); see(3'd4, 8'h03, "R9");
        day_end(8'h28, 8'h02, 8'h00); see(3'd3, 8'h29, "R9");
        // R10 year end
        day_end(8'h31, 8'h12, 8'h99);
        see(3'd3, 8'h01, "R10"); see(3'd4, 8'h01, "R10"); see(3'd5, 8'h00, "R10");
        day_end(8'h31, 8'h12, 8'h19); see(3'd5, 8'h20, "R10");
        // R12 event freeze
        wr(3'd0, 8'h40); pulse_event(); chk(halted, 1'b0, "R12");
        ticks(4); see(3'd0, 8'h41, "R12");
        pulse_arm(); chk(halt_armed, 1'b1, "R12");
        pulse_event(); chk(halted, 1'b1, "R12");
        ticks(8); see(3'd0, 8'h41, "R12");
        wr(3'd0, 8'h05); chk(halted, 1'b0, "R12"); chk(halt_armed, 1'b0, "R12");
        ticks(4); see(3'd0, 8'h06, "R12");
        // R13 snapshot coherence
        wr(3'd0, 8'h20); ticks(3); probe(3'd0, 1'b1, 8'h20, "R13");
        ticks(1); probe(3'd0, 1'b0, 8'h20, "R13");
        probe(3'd7, 1'b0, 8'h00, "R13");
        probe(3'd0, 1'b1, 8'h21, "R13");
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule